// File: doc/BRIEF.md
# Floating-Point Control and Status Register File

This block holds the floating-point unit's control and status word and serves it to software through several register indices. Index 31 is the full word. Indices 25, 26 and 28 are narrow views packed into the same storage: the eight condition codes, the exception cause and flag fields, and the enable, rounding and flush controls. Index 0 is a read-only identification constant. The datapath sees the current rounding mode and the flush-to-zero control as plain outputs.

After each arithmetic operation, the datapath presents one status word of six cause bits. The block replaces the cause field with that status. It raises a trap request when an enabled cause is present or when the unimplemented-operation cause is set, and it accumulates the ordinary causes into sticky flags. Compare units can set individual condition codes directly.

Top module: `fpcsr_regs`

## Requirements
- R1: A read of index 0 returns the parameter ID_VALUE (default 32'h0000_A5C3). A write to index 0 changes no state. A read of any index other than 0, 25, 26, 28 and 31 returns zero, and a write to such an index changes no state.
- R2: The full word (index 31) has this layout: rounding mode in bits 1:0, flags in 6:2, enables in 11:7, cause in 17:12, condition code 0 at bit 23, flush at bit 24, and condition codes 1 to 7 at bits 31:25. Bits 22:18 always read zero, and a write to index 31 stores the written data with those bits cleared.
- R3: Index 25 reads the eight condition codes packed into bits 7:0, with code 0 at bit 0 and code k at bit k; all other bits read zero. A write to index 25 updates only the condition codes.
- R4: Index 26 reads the cause field (17:12) and the flags field (6:2) at their full-word positions, with all other bits zero. A write to index 26 replaces only those two fields.
- R5: Index 28 reads the enables (11:7) and the rounding mode (1:0) at their full-word positions, and the flush bit at bit 2. A write to index 28 takes flush from bit 2 of the data and replaces flush, enables and rounding mode. It leaves the condition codes, cause and flags unchanged, and bit 24 of the written data is ignored.
- R6: The status bits are: inexact at bit 0, underflow at bit 1, overflow at bit 2, divide-by-zero at bit 3, invalid at bit 4, and unimplemented at bit 5. When op_valid is high, the cause field is replaced by op_status. Bits 4:0 of op_status are ORed into the flags, and the unimplemented bit never reaches the flags. This update takes priority over a software write to the same fields in the same cycle.
- R7: trap_req is high in the cycle after an operation exactly when (op_status[4:0] & enables) is nonzero or op_status[5] is set, using the enables held before that edge. Otherwise trap_req is low.
- R8: When cc_set_en[k] is high, condition code k takes cc_set_val[k] at the clock edge, with priority over a software write in the same cycle. round_mode and flush_zero always show the stored rounding mode and flush bit. The rounding mode is encoded 0 for nearest-even, 1 for toward zero, 2 for toward +infinity and 3 for toward -infinity.
- R9: After reset the full word is zero and trap_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | 5 | Register index for read and write |
| wr_en | input | 1 | Write strobe for the indexed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for reg_idx |
| op_valid | input | 1 | An operation has completed this cycle |
| op_status | input | 6 | Cause bits of the completed operation |
| cc_set_en | input | 8 | Per-code condition-code set strobes |
| cc_set_val | input | 8 | Values for strobed condition codes |
| trap_req | output | 1 | Registered trap request |
| round_mode | output | 2 | Current rounding mode |
| flush_zero | output | 1 | Current flush-to-zero control |

## Verification
On every cycle, the assertions check that the reserved bits stay zero and that the identification read is stable. They also check that an operation's status lands in the cause field one edge later, that flags only rise unless software writes, that an unimplemented cause always traps, that no trap appears without an operation, and that a direct condition-code set takes effect. The packing of the alias views, the gap around the flush bit, the preserved fields on partial writes, and the trap decision for each combination of enables and status can only be shown by the bench's sweeps, which read each view back after known writes.

// File: rtl/fpcsr_regs.sv
module fpcsr_regs #(
  parameter logic [31:0] ID_VALUE = 32'h0000_A5C3,
  parameter int          NCC      = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [4:0]     reg_idx,
  input  logic           wr_en,
  input  logic [31:0]    wr_data,
  output logic [31:0]    rd_data,
  input  logic           op_valid,
  input  logic [5:0]     op_status,
  input  logic [NCC-1:0] cc_set_en,
  input  logic [NCC-1:0] cc_set_val,
  output logic           trap_req,
  output logic [1:0]     round_mode,
  output logic           flush_zero
);
  localparam logic [31:0] RSV_MASK = 32'h007C_0000;

  logic [31:0] csr_q, csr_wr, csr_nx;
  logic        trap_q;
  logic [7:0]  cc_packed;

  assign cc_packed  = {csr_q[31:25], csr_q[23]};
  assign round_mode = csr_q[1:0];
  assign flush_zero = csr_q[24];
  assign trap_req   = trap_q;

  always_comb begin
    csr_wr = csr_q;
    case (reg_idx)
      5'd25: begin
        csr_wr[31:25] = wr_data[7:1];
        csr_wr[23]    = wr_data[0];
      end
      5'd26: begin
        csr_wr[17:12] = wr_data[17:12];
        csr_wr[6:2]   = wr_data[6:2];
      end
      5'd28: begin
        csr_wr[24]   = wr_data[2];
        csr_wr[11:7] = wr_data[11:7];
        csr_wr[1:0]  = wr_data[1:0];
      end
      5'd31:   csr_wr = wr_data & ~RSV_MASK;
      default: csr_wr = csr_q;
    endcase
  end

  always_comb begin
    csr_nx = wr_en ? csr_wr : csr_q;
    if (op_valid) begin
      csr_nx[17:12] = op_status;
      csr_nx[6:2]   = csr_nx[6:2] | op_status[4:0];
    end
    for (int k = 0; k < NCC; k++)
      if (cc_set_en[k]) csr_nx[(k == 0) ? 23 : 24 + k] = cc_set_val[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      csr_q  <= csr_nx;
      trap_q <= op_valid && ((|(op_status[4:0] & csr_q[11:7])) || op_status[5]);
    end
  end

  always_comb begin
    case (reg_idx)
      5'd0:    rd_data = ID_VALUE;
      5'd25:   rd_data = {24'd0, cc_packed};
      5'd26:   rd_data = csr_q & 32'h0003_F07C;
      5'd28:   rd_data = {20'd0, csr_q[11:7], 4'd0, csr_q[24], csr_q[1:0]};
      5'd31:   rd_data = csr_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/fpcsr_regs_chk.sv
module fpcsr_regs_chk #(
  parameter logic [31:0] ID_VALUE = 32'h0000_A5C3
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  reg_idx,
  input logic        wr_en,
  input logic [31:0] rd_data,
  input logic        op_valid,
  input logic [5:0]  op_status,
  input logic [7:0]  cc_set_en,
  input logic [7:0]  cc_set_val,
  input logic        trap_req,
  input logic [31:0] csr
);
  a_r1_id_read: assert property (@(posedge clk) disable iff (!rst_n)
    reg_idx == 5'd0 |-> rd_data == ID_VALUE);
  a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr[22:18] == 5'd0);
  a_r6_cause_load: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> csr[17:12] == $past(op_status));
  a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (($past(csr[6:2]) & ~csr[6:2]) == 5'd0));
  a_r7_unimpl_trap: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_status[5] |=> trap_req);
  a_r7_no_op_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !trap_req);
  a_r8_cc0_set: assert property (@(posedge clk) disable iff (!rst_n)
    cc_set_en[0] |=> csr[23] == $past(cc_set_val[0]));
endmodule

bind fpcsr_regs fpcsr_regs_chk #(.ID_VALUE(ID_VALUE)) chk (
  .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
  .rd_data(rd_data), .op_valid(op_valid), .op_status(op_status),
  .cc_set_en(cc_set_en), .cc_set_val(cc_set_val), .trap_req(trap_req),
  .csr(csr_q)
);

// File: tb/fpcsr_regs_test.sv
module fpcsr_regs_test;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] ID   = 32'h0000_A5C3;
  localparam logic [31:0] RSV  = 32'h007C_0000;
  localparam logic [31:0] EXCM = 32'h0003_F07C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_idx = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        op_valid = 1'b0;
  logic [5:0]  op_status = '0;
  logic [7:0]  cc_set_en = '0;
  logic [7:0]  cc_set_val = '0;
  logic        trap_req;
  logic [1:0]  round_mode;
  logic        flush_zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcsr_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .op_valid(op_valid),
    .op_status(op_status), .cc_set_en(cc_set_en), .cc_set_val(cc_set_val),
    .trap_req(trap_req), .round_mode(round_mode), .flush_zero(flush_zero)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] idx, output logic [31:0] d);
    reg_idx = idx;
    #1;
    d = rd_data;
  endtask

  task automatic op(input logic [5:0] s);
    @(negedge clk);
    op_valid = 1'b1; op_status = s;
    @(negedge clk);
    op_valid = 1'b0; op_status = '0;
  endtask

  function automatic logic [31:0] cc_expand(input logic [7:0] v);
    return (32'(v >> 1) << 25) | (32'(v & 8'd1) << 23);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state, R1 index sweep
    check("R9 trap_req", 32'(trap_req), 0);
    check("R9 round_mode", 32'(round_mode), 0);
    check("R9 flush_zero", 32'(flush_zero), 0);
    for (int i = 0; i < 32; i++) begin
      rd(5'(i), v);
      check(i == 0 ? "R1 id read" : "R9 R1 reset read", v, i == 0 ? ID : 32'd0);
    end

    // R1 writes to index 0 and unlisted indices ignored
    wr(5'd0, 32'hFFFF_FFFF);
    wr(5'd7, 32'hFFFF_FFFF);
    wr(5'd30, 32'hFFFF_FFFF);
    rd(5'd31, v); check("R1 ignored writes", v, 32'd0);
    rd(5'd0, v);  check("R1 id after write", v, ID);

    // R2 full write masks reserved, views from full word
    wr(5'd31, 32'hFFFF_FFFF);
    rd(5'd31, v); check("R2 reserved masked", v, ~RSV);
    rd(5'd25, v); check("R3 cc view all ones", v, 32'h0000_00FF);
    rd(5'd26, v); check("R4 exc view", v, EXCM);
    rd(5'd28, v); check("R5 en view", v, 32'h0000_0F87);
    check("R8 round_mode", 32'(round_mode), 3);
    check("R8 flush_zero", 32'(flush_zero), 1);
    for (int m = 0; m < 4; m++) begin
      wr(5'd31, 32'(m));
      check("R8 round_mode sweep", 32'(round_mode), 32'(m));
    end

    // R3 condition-code view sweep
    wr(5'd31, 32'd0);
    for (int i = 0; i < 256; i++) begin
      wr(5'd25, 32'hFFFF_FF00 | 32'(i));
      rd(5'd25, v); check("R3 cc read", v, 32'(i));
      rd(5'd31, v); check("R3 cc full", v, cc_expand(8'(i)));
    end

    // R4 exceptions view write replaces only cause/flags
    wr(5'd31, 32'hFFFF_FFFF);
    wr(5'd26, 32'd0);
    rd(5'd31, v); check("R4 exc clear", v, ~RSV & ~EXCM);
    wr(5'd26, 32'hFFFF_FFFF);
    rd(5'd31, v); check("R4 exc set", v, ~RSV);

    // R5 enables view write
    wr(5'd31, 32'd0);
    wr(5'd26, 32'h0003_F07C);
    wr(5'd25, 32'h0000_00FF);
    wr(5'd28, 32'h0000_0F86);
    rd(5'd31, v); check("R5 en write keeps", v, 32'hFF83_FFFE);
    rd(5'd28, v); check("R5 en read", v, 32'h0000_0F86);
    wr(5'd28, 32'h0100_0000);
    rd(5'd31, v); check("R5 bit24 ignored", v, 32'hFE83_F07C);
    check("R8 flush off", 32'(flush_zero), 0);

    // R6 R7 status sweep across enable patterns
    for (int e = 0; e < 4; e++) begin
      logic [4:0] en;
      en = (e == 0) ? 5'h00 : (e == 1) ? 5'h1F : (e == 2) ? 5'h15 : 5'h0A;
      for (int s = 0; s < 64; s++) begin
        wr(5'd31, 32'(en) << 7);
        op(6'(s));
        check("R7 trap decision", 32'(trap_req),
              32'(((s & 31) & en) != 0 || s >= 32));
        rd(5'd26, v);
        check("R6 cause and flags", v, (32'(s) << 12) | (32'(s & 31) << 2));
        @(negedge clk);
        check("R7 trap one cycle", 32'(trap_req), 0);
      end
    end

    // R6 sticky flags across operations
    wr(5'd31, 32'd0);
    op(6'h01);
    op(6'h28);
    op(6'h00);
    rd(5'd26, v); check("R6 sticky flags", v, 32'h0000_0024);
    op(6'h20);
    rd(5'd26, v); check("R6 unimpl not sticky", v, 32'h0002_0024);

    // R6 op beats same-cycle write to exceptions view
    @(negedge clk);
    reg_idx = 5'd26; wr_data = 32'h0003_F07C; wr_en = 1'b1;
    op_valid = 1'b1; op_status = 6'h02;
    @(negedge clk);
    wr_en = 1'b0; op_valid = 1'b0; op_status = '0;
    rd(5'd26, v); check("R6 op over write", v, 32'h0000_207C);

    // R8 direct cc set beats same-cycle write
    wr(5'd25, 32'h0000_0000);
    @(negedge clk);
    reg_idx = 5'd25; wr_data = 32'h0000_007E; wr_en = 1'b1;
    cc_set_en = 8'h81; cc_set_val = 8'h01;
    @(negedge clk);
    wr_en = 1'b0; cc_set_en = '0; cc_set_val = '0;
    rd(5'd25, v); check("R8 cc set priority", v, 32'h0000_007F);
    @(negedge clk);
    cc_set_en = 8'h3C; cc_set_val = 8'h14;
    @(negedge clk);
    cc_set_en = '0; cc_set_val = '0;
    rd(5'd25, v); check("R8 cc set partial", v, 32'h0000_0057);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule